// File: doc/BRIEF.md
# Per-Channel Digital Input Interrupt Controller

This block watches a bank of digital input pins and turns activity on them into a single interrupt request. Every channel is configured on its own: it either reports any transition of its pin (change-of-state mode) or reports while its pin sits at a chosen level (level-match mode). Events are latched into a sticky status register that software clears by writing ones. A per-channel enable selects which channels may latch events and which latched events reach the request line. A global enable in a control register gates the request line as a whole.

Software reaches the block through a small synchronous register bus. Writes take effect at the rising clock edge when `bus_wr` is high. Reads are combinational from `bus_addr`. Each pin passes through a two-flop synchronizer. The synchronized levels can be read back directly. In level-match mode a status bit cannot be cleared while its pin still matches the selected level. Software is therefore expected to mask the channel, wait for the stimulus to go away, then clear the bit and unmask the channel.

Top module: `chan_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Register map by `bus_addr`: 0 control, 1 mode, 2 polarity, 3 enable, 4 status, 5 input level; other addresses read 0. The mode, polarity and enable registers read back what was written. The control register keeps only bit 2 (module interrupt enable) and bit 3 (auxiliary enable); its other bits read 0.
- R3: Address 5 returns the synchronized pin levels. A pin change sets a change-of-state status bit at the third rising clock edge after the change, not earlier.
- R4: A channel whose mode bit is 1 (change-of-state) sets its status bit on both rising and falling transitions of its pin.
- R5: A channel whose mode bit is 0 (level match) sets its status bit while its pin equals its polarity bit, where 1 means high and 0 means low.
- R6: A channel whose enable bit is 0 never sets its status bit.
- R7: Writing 1 to a status bit clears it, unless R8 blocks the clear. Writing 0 leaves the bit unchanged.
- R8: A level-match channel whose pin still equals its polarity ignores a clear write, even when the channel is disabled.
- R9: When a set and a clear reach the same status bit in the same cycle, the bit ends up set.
- R10: `irq_o` is high exactly when control bit 2 is 1 and some status bit has its enable bit set. Control bit 3 has no effect on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NCH | Write data |
| bus_rdata | output | NCH | Read data, combinational from `bus_addr` |
| din | input | NCH | Asynchronous digital input pins |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a change-of-state event and a clear write landing on the same status bit at the same edge. The bench first latches the bit. It then toggles the pin and raises the clear write so that the write is sampled at the third rising edge after the toggle, which is the edge at which the synchronized change sets the bit. The blocked level-mode clear is easier to set up: the channel is masked first, so `irq_o` drops, and the bench then shows that the status bit survives clear writes until the pin level moves away from the polarity.

// File: rtl/chan_irq_pkg.sv
// Package: register selectors and control-bit positions shared by the
// interrupt controller modules. Assumes a 3-bit register address.
package chan_irq_pkg;

    localparam int ADDR_W       = 3;
    localparam int CTRL_MIE_BIT = 2;
    localparam int CTRL_AUX_BIT = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL  = 3'd0,
        SEL_MODE  = 3'd1,
        SEL_POL   = 3'd2,
        SEL_ENA   = 3'd3,
        SEL_STAT  = 3'd4,
        SEL_LEVEL = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/chan_irq_sync.sv
// Module: two-flop synchronizer per channel, plus one more register that
// holds the previous synchronized value for transition detection.
// Assumes the pins are asynchronous to clk and need no debouncing.
module chan_irq_sync #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] din,
    output logic [NCH-1:0] lvl,
    output logic [NCH-1:0] lvl_prev
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic meta_q;
        logic sync_q;
        logic prev_q;

        // Purpose: move the pin into the clock domain and keep one cycle of history.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= din[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign lvl[g]      = sync_q;
        assign lvl_prev[g] = prev_q;
    end

endmodule

// File: rtl/chan_irq_detect.sv
// Module: per-channel event qualifier. It selects transition detection or
// level comparison according to the mode bit. It is purely combinational
// and assumes synchronized inputs.
module chan_irq_detect #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0] lvl,
    input  logic [NCH-1:0] lvl_prev,
    input  logic [NCH-1:0] mode_cos,
    input  logic [NCH-1:0] pol,
    output logic [NCH-1:0] match,
    output logic [NCH-1:0] evt
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic toggled;

        // Purpose: compare the level with the polarity and detect a transition.
        always_comb begin
            match[g] = ~(lvl[g] ^ pol[g]);
            toggled  = lvl[g] ^ lvl_prev[g];
            evt[g]   = mode_cos[g] ? toggled : match[g];
        end
    end

endmodule

// File: rtl/chan_irq_status.sv
// Module: sticky status bits with write-one-to-clear. A set wins over a
// clear in the same cycle. A clear is held off while a level-match
// channel still matches. Assumes clr is a one-cycle strobe vector.
module chan_irq_status #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic [NCH-1:0] match,
    input  logic [NCH-1:0] mode_cos,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] status
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hold;
        logic set;
        logic eff_clr;
        logic st_q;

        // Purpose: work out the set and the effective clear for this channel.
        always_comb begin
            hold    = ~mode_cos[g] & match[g];
            set     = evt[g] & en[g];
            eff_clr = clr[g] & ~hold;
        end

        // Purpose: hold the sticky status bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= 1'b0;
            end else begin
                st_q <= set | (st_q & ~eff_clr);
            end
        end

        assign status[g] = st_q;
    end

endmodule

// File: rtl/chan_irq_regs.sv
// Module: configuration registers, the status clear strobe and the read
// multiplexer. Assumes NCH >= 4 so the control bits fit the data width.
module chan_irq_regs
    import chan_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NCH-1:0]    bus_wdata,
    input  logic [NCH-1:0]    status,
    input  logic [NCH-1:0]    lvl,
    output logic [NCH-1:0]    bus_rdata,
    output logic [NCH-1:0]    mode_cos,
    output logic [NCH-1:0]    pol,
    output logic [NCH-1:0]    en,
    output logic [NCH-1:0]    clr,
    output logic              mie
);

    localparam logic [NCH-1:0] CTRL_MASK =
        (NCH'(1) << CTRL_MIE_BIT) | (NCH'(1) << CTRL_AUX_BIT);

    logic [NCH-1:0] ctrl_q;
    logic [NCH-1:0] mode_q;
    logic [NCH-1:0] pol_q;
    logic [NCH-1:0] en_q;

    // Purpose: capture configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                SEL_CTRL: ctrl_q <= bus_wdata & CTRL_MASK;
                SEL_MODE: mode_q <= bus_wdata;
                SEL_POL:  pol_q  <= bus_wdata;
                SEL_ENA:  en_q   <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: form the clear strobe for the status bank.
    always_comb begin
        clr = (bus_wr && bus_addr == SEL_STAT) ? bus_wdata : '0;
    end

    // Purpose: select read data.
    always_comb begin
        case (bus_addr)
            SEL_CTRL:  bus_rdata = ctrl_q;
            SEL_MODE:  bus_rdata = mode_q;
            SEL_POL:   bus_rdata = pol_q;
            SEL_ENA:   bus_rdata = en_q;
            SEL_STAT:  bus_rdata = status;
            SEL_LEVEL: bus_rdata = lvl;
            default:   bus_rdata = '0;
        endcase
    end

    assign mode_cos = mode_q;
    assign pol      = pol_q;
    assign en       = en_q;
    assign mie      = ctrl_q[CTRL_MIE_BIT];

endmodule

// File: rtl/chan_irq_ctrl.sv
// Module: top of the per-channel digital input interrupt controller.
// It joins the synchronizer, event detector, status bank and registers,
// and drives one request line gated by the module enable.
// Assumes NCH >= 4.
module chan_irq_ctrl
    import chan_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NCH-1:0]    bus_wdata,
    output logic [NCH-1:0]    bus_rdata,
    input  logic [NCH-1:0]    din,
    output logic              irq_o
);

    logic [NCH-1:0] lvl;
    logic [NCH-1:0] lvl_prev;
    logic [NCH-1:0] mode_cos;
    logic [NCH-1:0] pol;
    logic [NCH-1:0] en;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] match;
    logic [NCH-1:0] evt;
    logic [NCH-1:0] status;
    logic           mie;

    chan_irq_sync #(.NCH(NCH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    chan_irq_detect #(.NCH(NCH)) u_detect (
        .lvl      (lvl),
        .lvl_prev (lvl_prev),
        .mode_cos (mode_cos),
        .pol      (pol),
        .match    (match),
        .evt      (evt)
    );

    chan_irq_status #(.NCH(NCH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .match    (match),
        .mode_cos (mode_cos),
        .en       (en),
        .clr      (clr),
        .status   (status)
    );

    chan_irq_regs #(.NCH(NCH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status    (status),
        .lvl       (lvl),
        .bus_rdata (bus_rdata),
        .mode_cos  (mode_cos),
        .pol       (pol),
        .en        (en),
        .clr       (clr),
        .mie       (mie)
    );

    // Purpose: combine the enabled status bits into the gated request.
    always_comb begin
        irq_o = mie & (|(status & en));
    end

endmodule

// File: rtl/chan_irq_ctrl_chk.sv
// Checker: temporal properties of the interrupt controller, bound to the top.
module chan_irq_ctrl_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] status,
    input logic [NCH-1:0] en,
    input logic [NCH-1:0] mode_cos,
    input logic [NCH-1:0] match,
    input logic [NCH-1:0] evt,
    input logic [NCH-1:0] clr,
    input logic           mie,
    input logic           irq_o
);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !mie |-> !irq_o);  // R10

    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(en)) == '0));  // R6

    AST_NO_SPONT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~status & ~$past(clr)) == '0));  // R7

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~status & $past(~mode_cos & match)) == '0));  // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt & en) & ~status) == '0));  // R9

endmodule

bind chan_irq_ctrl chan_irq_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (status),
    .en       (en),
    .mode_cos (mode_cos),
    .match    (match),
    .evt      (evt),
    .clr      (clr),
    .mie      (mie),
    .irq_o    (irq_o)
);

// File: tb/chan_irq_ctrl_tb.sv
module chan_irq_ctrl_tb;

    localparam int NCH = 8;
    localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_POL = 3'd2,
                           A_ENA = 3'd3, A_STAT = 3'd4, A_LVL = 3'd5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [2:0]     bus_addr = '0;
    logic [NCH-1:0] bus_wdata = '0;
    logic [NCH-1:0] bus_rdata;
    logic [NCH-1:0] din = '0;
    logic           irq_o;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    chan_irq_ctrl #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [NCH-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [NCH-1:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_chk("R1 reset reg", 3'(a), '0);
        check("R1 reset irq", 32'(irq_o), 0);
    endtask

    task automatic t_regs();
        wr(A_CTRL, 8'hFF);
        rd_chk("R2 ctrl keeps bits 2,3", A_CTRL, 8'h0C);
        wr(A_CTRL, 8'h08);
        wr(A_MODE, 8'h11);
        rd_chk("R2 mode", A_MODE, 8'h11);
        wr(A_POL, 8'h04);
        rd_chk("R2 pol", A_POL, 8'h04);
        rd_chk("R2 unused addr", 3'd7, '0);
    endtask

    task automatic t_level_read();
        din = 8'hA5; settle();
        rd_chk("R3 level readback", A_LVL, 8'hA5);
        din = 8'h00; settle();
        rd_chk("R6 nothing enabled, no status", A_STAT, '0);
    endtask

    task automatic t_cos();
        wr(A_ENA, 8'h11);
        rd_chk("R4 quiet inputs no status", A_STAT, '0);
        din[0] = 1'b1; settle();
        rd_chk("R4 rising edge sets", A_STAT, 8'h01);
        check("R10 aux enable alone no irq", 32'(irq_o), 0);
        wr(A_CTRL, 8'h04);
        #1 check("R10 module enable gives irq", 32'(irq_o), 1);
        wr(A_STAT, 8'h00);
        rd_chk("R7 write 0 keeps bit", A_STAT, 8'h01);
        wr(A_STAT, 8'h01);
        rd_chk("R7 write 1 clears bit", A_STAT, 8'h00);
        check("R10 irq drops after clear", 32'(irq_o), 0);
        din[0] = 1'b0; settle();
        rd_chk("R4 falling edge sets", A_STAT, 8'h01);
        wr(A_STAT, 8'h01);
    endtask

    task automatic t_disabled();
        din[1] = 1'b1; settle();
        din[1] = 1'b0; settle();
        rd_chk("R6 disabled channel stays clear", A_STAT, 8'h00);
    endtask

    task automatic t_latency();
        @(negedge clk); bus_addr = A_STAT; din[4] = 1'b1;
        @(negedge clk); #1 check("R3 not set after 1 edge", 32'(bus_rdata[4]), 0);
        @(negedge clk); #1 check("R3 not set after 2 edges", 32'(bus_rdata[4]), 0);
        @(negedge clk); #1 check("R3 set after 3 edges", 32'(bus_rdata[4]), 1);
    endtask

    task automatic t_set_wins();
        @(negedge clk); din[4] = 1'b0;
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 8'h10;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
        rd_chk("R9 set wins over clear", A_STAT, 8'h10);
        wr(A_STAT, 8'h10);
        rd_chk("R7 clear after collision", A_STAT, 8'h00);
    endtask

    task automatic t_level();
        wr(A_ENA, 8'h15);
        rd_chk("R5 no match no status", A_STAT, 8'h00);
        din[2] = 1'b1; settle();
        rd_chk("R5 high match sets", A_STAT, 8'h04);
        check("R10 irq on level", 32'(irq_o), 1);
        wr(A_ENA, 8'h11);
        #1 check("R10 masked channel no irq", 32'(irq_o), 0);
        wr(A_STAT, 8'h04);
        rd_chk("R8 clear blocked while matching", A_STAT, 8'h04);
        din[2] = 1'b0; settle();
        rd_chk("R8 bit stays until cleared", A_STAT, 8'h04);
        wr(A_STAT, 8'h04);
        rd_chk("R7 clear after stimulus gone", A_STAT, 8'h00);
        wr(A_POL, 8'h00);
        wr(A_ENA, 8'h15);
        settle();
        rd_chk("R5 low match sets", A_STAT, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_level_read();
        t_cos();
        t_disabled();
        t_latency();
        t_set_wins();
        t_level();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule